// File: doc/BRIEF.md
# Rate-Half Convolutional Encoder

This block encodes a serial bit stream with a rate 1/2, constraint-length-3 convolutional code. Each accepted data bit produces one two-bit code symbol. The block stores the two preceding input bits, so it has four possible states. The generator taps are fixed. The upper symbol bit is the XOR of the current bit and both stored bits. The lower symbol bit is the XOR of the current bit and the bit accepted two steps earlier.

Input uses a ready/valid handshake. Output is a registered symbol with a one-cycle valid strobe. A frame-start pulse makes the encoder start from the all-zeros state. A tail request appends two zero bits so that the trellis finishes in state zero. While those two tail bits are injected, the encoder holds `in_ready` low.

Top module: `conv_enc_r2k3`

## Requirements
- R1: After synchronous active-high reset, `in_ready` is 1 and `out_valid` is 0. The first bit accepted after reset is encoded as if both earlier bits were 0.
- R2: For a step with current bit I(t) and earlier bits I(t-1), I(t-2), `out_sym[1]` = I(t) ^ I(t-1) ^ I(t-2). Example: with I(t-1)=1, I(t-2)=0 and I(t)=1, `out_sym` is 2'b01.
- R3: `out_sym[0]` = I(t) ^ I(t-2).
- R4: `out_valid` is 1 in the cycle after each accepted bit (`in_valid` and `in_ready` both high) or tail step. It is 0 after a cycle with neither.
- R5: The state advances only on an accepted bit or a tail step. Idle cycles do not change it. A bit offered while `in_ready` is 0 is discarded.
- R6: When `frame_start` is high in the same cycle as an accepted bit, that bit is encoded from the all-zeros state. When `frame_start` is high with no accepted bit, the state becomes zero.
- R7: A `flush_req` sampled while `in_ready` is 1 holds `in_ready` low for the next two cycles. It emits two symbols computed with a zero input bit, one after each of those edges. After that the state is zero and `in_ready` returns to 1. A bit accepted in the same cycle as the request is encoded before the tail.
- R8: `flush_req` is ignored while `in_ready` is 0. When `flush_req` and `frame_start` are high together, `frame_start` wins, no tail is produced and the state becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | Clears the state for a new frame |
| flush_req | input | 1 | Requests two zero tail bits |
| in_valid | input | 1 | Input bit offered |
| in_bit | input | 1 | Data bit |
| in_ready | output | 1 | Encoder can accept a bit this cycle |
| out_valid | output | 1 | `out_sym` holds a new symbol |
| out_sym | output | 2 | Code symbol, [1] = three-tap output, [0] = two-tap output |

## Verification
- **Bit timing.** A symbol for a bit accepted at an edge appears one cycle later, and each check samples it at the falling edge right after that edge.
- **Tail timing.** For a tail request sampled at edge P0:
  - `in_ready` reads low after P0 and after P1.
  - The first tail symbol is checked after P1 and the second after P2.
  - `in_ready` is checked high again after P2.
- **Coverage.** A bench history model supplies the expected symbols. It covers all eight three-bit histories, a long pseudo-random stream with idle gaps and frame starts, and the ignored-input and ignored-request cases.

// File: rtl/conv_enc_r2k3.sv
module conv_enc_r2k3 (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_start,
  input  logic       flush_req,
  input  logic       in_valid,
  input  logic       in_bit,
  output logic       in_ready,
  output logic       out_valid,
  output logic [1:0] out_sym
);
  localparam int K        = 3;
  localparam int MEM      = K - 1;
  localparam int TAIL_W   = $clog2(MEM + 1);

  // hist[0] = previous bit, hist[1] = bit two steps back
  logic [MEM-1:0]    hist;
  logic [TAIL_W-1:0] tail_cnt;
  logic              tailing, take, step, cur;
  logic [MEM-1:0]    base;

  assign tailing  = |tail_cnt;
  assign in_ready = ~tailing;
  assign take     = in_valid & in_ready;
  assign step     = take | (tailing & ~frame_start);
  assign cur      = take & in_bit;
  assign base     = frame_start ? '0 : hist;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist      <= '0;
      tail_cnt  <= '0;
      out_valid <= 1'b0;
      out_sym   <= 2'b00;
    end else begin
      out_valid <= step;
      if (step) begin
        out_sym <= {base[1] ^ base[0] ^ cur, base[1] ^ cur};
        hist    <= {base[0], cur};
      end else if (frame_start) begin
        hist <= '0;
      end
      if (frame_start)
        tail_cnt <= '0;
      else if (tailing)
        tail_cnt <= tail_cnt - 1'b1;
      else if (flush_req)
        tail_cnt <= TAIL_W'(MEM);
    end
  end

  assert_valid_follows_R4: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid);
  assert_quiet_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !take) |=> !out_valid);
  assert_state_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !take && !frame_start) |=> $stable(hist));
  assert_frame_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (frame_start && !take) |=> (hist == '0));
  assert_ready_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (flush_req && in_ready && !frame_start) |=> !in_ready);
  assert_tail_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (tail_cnt == TAIL_W'(1) && !frame_start) |=> (hist == '0 && out_valid && in_ready));
  assert_start_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (frame_start && in_ready) |=> in_ready);
endmodule

// File: tb/conv_enc_r2k3_bench.sv
module conv_enc_r2k3_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_start = 1'b0, flush_req = 1'b0, in_valid = 1'b0, in_bit = 1'b0;
  logic in_ready, out_valid;
  logic [1:0] out_sym;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic h1 = 1'b0, h2 = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  conv_enc_r2k3 u_conv_enc_r2k3 (
    .clk(clk), .rst(rst), .frame_start(frame_start), .flush_req(flush_req),
    .in_valid(in_valid), .in_bit(in_bit), .in_ready(in_ready),
    .out_valid(out_valid), .out_sym(out_sym)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // drive at a falling edge, check at the next falling edge
  task automatic send(input logic b, input logic fs, input string tag);
    logic [1:0] e;
    chk(in_ready == 1'b1, "R7 ready before send", {1'b0, in_ready}, 2'b01);
    in_valid = 1'b1; in_bit = b; frame_start = fs;
    @(posedge clk); @(negedge clk);
    if (fs) begin h1 = 1'b0; h2 = 1'b0; end
    e = {h2 ^ h1 ^ b, h2 ^ b};
    chk(out_valid == 1'b1, "R4 valid", {1'b0, out_valid}, 2'b01);
    chk(out_sym == e, tag, out_sym, e);
    h2 = h1; h1 = b;
    in_valid = 1'b0; frame_start = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      chk(out_valid == 1'b0, "R4 idle", {1'b0, out_valid}, 2'b00);
    end
  endtask

  task automatic tail_step(input logic rdy_exp, input string tag);
    logic [1:0] e;
    @(posedge clk); @(negedge clk);
    e = {h2 ^ h1, h2};
    chk(out_valid == 1'b1, "R7 tail valid", {1'b0, out_valid}, 2'b01);
    chk(out_sym == e, tag, out_sym, e);
    chk(in_ready == rdy_exp, "R7 tail ready", {1'b0, in_ready}, {1'b0, rdy_exp});
    h2 = h1; h1 = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready", {1'b0, in_ready}, 2'b01);
    chk(out_valid == 1'b0, "R1 valid", {1'b0, out_valid}, 2'b00);
    send(1'b1, 1'b0, "R1 first symbol from zero state");

    // worked example: prev 1, two back 0, current 1 -> 01
    send(1'b0, 1'b1, "R6 frame start");
    send(1'b1, 1'b0, "R2 R3 history");
    send(1'b1, 1'b0, "R2 R3 example");

    // every three-bit history
    for (int v = 0; v < 8; v++) begin
      send(v[2], 1'b1, "R6 sweep start");
      send(v[1], 1'b0, "R2 sweep");
      send(v[0], 1'b0, "R3 sweep");
      idle(1);
    end

    // tail after a bit accepted in the same cycle as the request
    send(1'b1, 1'b0, "R2 pre tail");
    in_valid = 1'b1; in_bit = 1'b1; flush_req = 1'b1;
    @(posedge clk); @(negedge clk);
    begin
      logic [1:0] e;
      e = {h2 ^ h1 ^ 1'b1, h2 ^ 1'b1};
      chk(out_sym == e, "R7 same-cycle bit first", out_sym, e);
      h2 = h1; h1 = 1'b1;
    end
    chk(in_ready == 1'b0, "R7 ready low", {1'b0, in_ready}, 2'b00);
    // ignored request and ignored input during the tail
    flush_req = 1'b1; in_valid = 1'b1; in_bit = 1'b1;
    tail_step(1'b0, "R7 tail symbol 1");
    flush_req = 1'b0;
    tail_step(1'b1, "R7 tail symbol 2");
    in_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(in_ready == 1'b1, "R8 request ignored while busy", {1'b0, in_ready}, 2'b01);
    chk(out_valid == 1'b0, "R5 no step", {1'b0, out_valid}, 2'b00);
    send(1'b1, 1'b0, "R5 R7 state zero after tail");

    // frame start beats a tail request
    send(1'b1, 1'b0, "R2 load");
    frame_start = 1'b1; flush_req = 1'b1;
    @(posedge clk); @(negedge clk);
    frame_start = 1'b0; flush_req = 1'b0;
    chk(in_ready == 1'b1, "R8 no tail", {1'b0, in_ready}, 2'b01);
    chk(out_valid == 1'b0, "R8 no symbol", {1'b0, out_valid}, 2'b00);
    h1 = 1'b0; h2 = 1'b0;
    send(1'b1, 1'b0, "R6 R8 cleared state");

    // frame start with no bit clears state
    send(1'b1, 1'b0, "R2 load2");
    frame_start = 1'b1;
    @(posedge clk); @(negedge clk);
    frame_start = 1'b0;
    h1 = 1'b0; h2 = 1'b0;
    send(1'b0, 1'b0, "R6 clear without bit");

    // pseudo-random stream with gaps and occasional frame starts
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send(lfsr[0], (lfsr[7:3] == 5'd0), "R2 R3 stream");
      if (lfsr[9:8] == 2'b00) idle(int'(lfsr[11:10]) + 1);
    end

    report();
  end
endmodule